// File: doc/BRIEF.md
# Quarter-Duty Half-Bias LCD Drive Sequencer

This block produces the drive codes for a multiplexed liquid-crystal panel with four common lines and a row of segment lines. It runs from a 75 kHz clock and walks through eight equal phases per frame. Each phase selects one common line under one of two polarities, which gives a 75 Hz frame. Every pin is reported as a two-bit level code: low, mid or high. An analog stage outside the block turns these codes into voltages. With half bias, a common line that is not selected rests at the mid level.

Each segment's display data is a nibble, one bit per common line. During a phase the block compares the segment's bit for the selected common with the phase polarity. It then drives the segment either opposite to the common, so the segment shows, or equal to it, so the segment stays blank. Two groups of four segment lines can each be handed over to general-purpose port logic with one mode bit per group. While a group is handed over, its segment codes are held low. Reset, backup and a cleared enable all force every code low. When drive resumes, the sequence restarts from its first phase.

Top module: `lcd_mux_drive`

## Requirements
- R1: While reset is asserted (rstN low), every common and segment code is 2'b00, and this holds immediately, without waiting for a clock edge.
- R2: When enabled, phase p (0 to 7) lasts exactly CLK_PER_PHASE clocks. Phase p selects common p mod 4 and uses positive polarity for p < 4 and negative polarity for p >= 4. Phase 0 follows phase 7, so one frame is 8 × CLK_PER_PHASE clocks. Phase 0 first appears at the outputs two clock edges after enable is sampled high.
- R3: During a phase, the selected common carries 2'b10 in positive polarity and 2'b00 in negative polarity. The other three commons carry 2'b01.
- R4: Segment s uses bit s*4+k of segData for common k. While common k is selected, a set bit drives the segment to the level opposite the selected common, and a clear bit drives it to the same level as the selected common.
- R5: With backup high, all codes are 2'b00 from the first clock edge after backup is sampled. After backup is released, output resumes at phase 0 on the second edge.
- R6: With enable low, all codes are 2'b00 from the first clock edge after enable is sampled low. A later enable restarts the sequence at phase 0, as in R2.
- R7: portMode bit g set holds the codes of segments SHARE_BASE+4g to SHARE_BASE+4g+3 at 2'b00 from the next clock edge. With the defaults, g=0 covers segments 11..14 and g=1 covers segments 15..18. All other segments and the commons are unaffected.
- R8: Level codes are 2'b00 low, 2'b01 mid and 2'b10 high. The code 2'b11 never appears.
- R9: A change of segData or portMode within a phase reaches the outputs on the next clock edge, without waiting for a phase boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 75 kHz drive clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Display drive on |
| backup | input | 1 | Backup state, forces all codes low |
| portMode | input | SHARE_GROUPS | Per-group hand-over of shared segment lines to port use |
| segData | input | SEG_N*4 | Display nibble per segment, bit k for common k |
| comLevel | output | 8 | Two-bit level code per common line, common k at [2k+1:2k] |
| segLevel | output | SEG_N*2 | Two-bit level code per segment line, segment s at [2s+1:2s] |

## Verification
A wrong divider count or phase register would shift every phase boundary. That shows at the commons within one phase, as a selected common that changes early or late, or a polarity that flips in the wrong half of the frame. A swapped polarity or nibble bit shows on the next clock edge as a segment equal to its common when it should be opposite, or the reverse. A wrong group decode shows as the wrong four segments going low. Restart faults after backup or enable show within two edges of the release, as a phase other than 0 at the outputs.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;
  localparam int COM_N   = 4;
  localparam int COM_W   = 2;
  localparam int PHASE_W = COM_W + 1;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } level_t;

  typedef struct packed {
    logic             drive;
    logic             polNeg;
    logic [COM_W-1:0] comSel;
  } phase_ctl_t;
endpackage

// File: rtl/lcd_phase_ctrl.sv
module lcd_phase_ctrl
  import lcd_mux_pkg::*;
#(
  parameter int CLK_PER_PHASE = 125
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       backup,
  output phase_ctl_t ctl
);
  localparam int DIV_W = (CLK_PER_PHASE > 1) ? $clog2(CLK_PER_PHASE) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_PHASE - 1);

  logic               running;
  logic [DIV_W-1:0]   divCnt;
  logic [PHASE_W-1:0] phase;
  logic               want;

  assign want = enable & ~backup;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      divCnt  <= '0;
      phase   <= '0;
    end else if (!want) begin
      running <= 1'b0;
      divCnt  <= '0;
      phase   <= '0;
    end else begin
      running <= 1'b1;
      if (running) begin
        if (divCnt == DIV_LAST) begin
          divCnt <= '0;
          phase  <= phase + 1'b1;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign ctl.drive  = running & want;
  assign ctl.polNeg = phase[PHASE_W-1];
  assign ctl.comSel = phase[COM_W-1:0];

  // R2: the divider never passes its last count
  p_div_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= DIV_LAST);

  // R2: the phase only moves on a divider wrap
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (running && want && divCnt != DIV_LAST) |=> $stable(phase));

  // R5 / R6: a stop returns the sequence to phase 0
  p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !want |=> (phase == '0 && divCnt == '0 && !running));
endmodule

// File: rtl/lcd_level_path.sv
module lcd_level_path
  import lcd_mux_pkg::*;
#(
  parameter int SEG_N        = 19,
  parameter int SHARE_BASE   = 11,
  parameter int SHARE_GROUPS = 2,
  parameter int GROUP_W      = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  phase_ctl_t              ctl,
  input  logic [SEG_N*COM_N-1:0]  segData,
  input  logic [SHARE_GROUPS-1:0] portMode,
  output logic [COM_N*2-1:0]      comLevel,
  output logic [SEG_N*2-1:0]      segLevel
);
  localparam int SHARE_END = SHARE_BASE + SHARE_GROUPS * GROUP_W;

  level_t selLvl;
  level_t oppLvl;

  always_comb begin
    selLvl = ctl.polNeg ? LVL_LOW : LVL_HIGH;
    oppLvl = ctl.polNeg ? LVL_HIGH : LVL_LOW;
  end

  logic [COM_N-1:0] comNotMid;

  for (genvar c = 0; c < COM_N; c++) begin : g_com
    level_t comNext;
    always_comb begin
      if (!ctl.drive)                 comNext = LVL_LOW;
      else if (ctl.comSel == COM_W'(c)) comNext = selLvl;
      else                            comNext = LVL_MID;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) comLevel[2*c +: 2] <= LVL_LOW;
      else       comLevel[2*c +: 2] <= comNext;
    end
    assign comNotMid[c] = (comLevel[2*c +: 2] != LVL_MID);

    // R8: reserved code never driven on a common
    p_com_code_r8: assert property (@(posedge clk) disable iff (!rstN)
      comLevel[2*c +: 2] != 2'b11);
  end

  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    logic             handed;
    logic [COM_N-1:0] nib;
    level_t           segNext;

    if (s >= SHARE_BASE && s < SHARE_END) begin : g_shared
      assign handed = portMode[(s - SHARE_BASE) / GROUP_W];
    end else begin : g_fixed
      assign handed = 1'b0;
    end

    assign nib = segData[s*COM_N +: COM_N];

    always_comb begin
      if (!ctl.drive || handed) segNext = LVL_LOW;
      else if (nib[ctl.comSel]) segNext = oppLvl;
      else                      segNext = selLvl;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) segLevel[2*s +: 2] <= LVL_LOW;
      else       segLevel[2*s +: 2] <= segNext;
    end

    // R7: a handed-over line reads low one edge later
    p_port_low_r7: assert property (@(posedge clk) disable iff (!rstN)
      handed |=> segLevel[2*s +: 2] == LVL_LOW);

    // R8: reserved code never driven on a segment
    p_seg_code_r8: assert property (@(posedge clk) disable iff (!rstN)
      segLevel[2*s +: 2] != 2'b11);
  end

  // R5 / R6: stopped drive gives all-low outputs on the next edge
  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.drive |=> (comLevel == '0 && segLevel == '0));

  // R3: while driving, exactly one common leaves the mid level
  p_one_selected_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.drive |=> $countones(comNotMid) == 1);
endmodule

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive
  import lcd_mux_pkg::*;
#(
  parameter int SEG_N         = 19,
  parameter int CLK_PER_PHASE = 125,
  parameter int SHARE_BASE    = 11,
  parameter int SHARE_GROUPS  = 2,
  parameter int GROUP_W       = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    backup,
  input  logic [SHARE_GROUPS-1:0] portMode,
  input  logic [SEG_N*4-1:0]      segData,
  output logic [7:0]              comLevel,
  output logic [SEG_N*2-1:0]      segLevel
);
  phase_ctl_t ctl;

  lcd_phase_ctrl #(
    .CLK_PER_PHASE(CLK_PER_PHASE)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .backup (backup),
    .ctl    (ctl)
  );

  lcd_level_path #(
    .SEG_N        (SEG_N),
    .SHARE_BASE   (SHARE_BASE),
    .SHARE_GROUPS (SHARE_GROUPS),
    .GROUP_W      (GROUP_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .segData  (segData),
    .portMode (portMode),
    .comLevel (comLevel),
    .segLevel (segLevel)
  );
endmodule

// File: tb/lcd_mux_drive_bench.sv
module lcd_mux_drive_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_N      = 19;
  localparam int PER        = 125;
  localparam int MAX_CYC    = 200000;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 enable = 1'b0;
  logic                 backup = 1'b0;
  logic [1:0]           portMode = 2'b00;
  logic [SEG_N*4-1:0]   segData = '0;
  logic [7:0]           comLevel;
  logic [SEG_N*2-1:0]   segLevel;

  int nChecks = 0;
  int nFails  = 0;
  int edgeCnt = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_mux_drive u_lcd_mux_drive (
    .clk(clk), .rstN(rstN), .enable(enable), .backup(backup),
    .portMode(portMode), .segData(segData),
    .comLevel(comLevel), .segLevel(segLevel)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      edgeCnt++;
    end
    @(negedge clk);
  endtask

  task automatic goTo(input int t);
    if (t > edgeCnt) step(t - edgeCnt);
  endtask

  function automatic void calc(input int ph, input bit on,
                               output logic [7:0] ec,
                               output logic [SEG_N*2-1:0] es);
    int cs;
    logic [1:0] selL, oppL;
    bit hand;
    cs   = ph % 4;
    selL = (ph >= 4) ? 2'b00 : 2'b10;
    oppL = (ph >= 4) ? 2'b10 : 2'b00;
    for (int c = 0; c < 4; c++)
      ec[2*c +: 2] = !on ? 2'b00 : ((c == cs) ? selL : 2'b01);
    for (int s = 0; s < SEG_N; s++) begin
      hand = (s >= 11 && s < 19) ? portMode[(s - 11) / 4] : 1'b0;
      es[2*s +: 2] = (!on || hand) ? 2'b00 : (segData[4*s + cs] ? oppL : selL);
    end
  endfunction

  task automatic check(input int ph, input bit on, input string tag);
    logic [7:0] ec;
    logic [SEG_N*2-1:0] es;
    calc(ph, on, ec, es);
    nChecks++;
    if (comLevel !== ec || segLevel !== es) begin
      nFails++;
      $display("FAIL %s: com=%h seg=%h expected com=%h seg=%h", tag,
               comLevel, segLevel, ec, es);
    end
  endtask

  // R1 / R8: outputs low under reset, also mid-run without a clock
  task automatic testReset();
    step(3);
    check(0, 0, "R1 reset state");
    rstN = 1'b1;
    step(2);
    check(0, 0, "R1 idle after reset");
  endtask

  // R2 / R3 / R4 / R8: full frame walk with phase boundaries
  task automatic testFrame();
    segData = 76'h5_A3C6_9F01_E7B2_48D5;
    enable = 1'b1;
    edgeCnt = 0;
    step(1);
    check(0, 0, "R2 first edge still low");
    step(1);
    check(0, 1, "R2 phase 0 start");
    for (int p = 0; p < 8; p++) begin
      goTo(126 + PER * p);
      check(p, 1, "R2 R3 R4 phase end");
      goTo(127 + PER * p);
      check((p + 1) % 8, 1, "R2 R3 R4 phase start");
    end
  endtask

  // R9 / R4: data change mid phase reaches the next edge
  task automatic testDataChange();
    int ph;
    goTo(edgeCnt + 40);
    ph = ((edgeCnt - 2) / PER) % 8;
    segData = ~segData;
    step(1);
    check(ph, 1, "R9 R4 new pattern");
    segData = {SEG_N{4'b1111}};
    step(1);
    check(ph, 1, "R4 all set");
    segData = '0;
    step(1);
    check(ph, 1, "R4 all clear");
    segData = 76'h1_2345_6789_ABCD_EF01_2;
  endtask

  // R7: group hand-over
  task automatic testPortMode();
    int ph;
    for (int m = 1; m < 4; m++) begin
      portMode = 2'(m);
      step(1);
      ph = ((edgeCnt - 2) / PER) % 8;
      check(ph, 1, "R7 port mode");
    end
    portMode = 2'b00;
    step(1);
    ph = ((edgeCnt - 2) / PER) % 8;
    check(ph, 1, "R7 back to segments");
  endtask

  // R5: backup forces low and restarts at phase 0
  task automatic testBackup();
    goTo(edgeCnt + 300);
    backup = 1'b1;
    step(1);
    check(0, 0, "R5 backup low");
    step(400);
    check(0, 0, "R5 backup held low");
    backup = 1'b0;
    edgeCnt = 0;
    step(1);
    check(0, 0, "R5 release first edge");
    step(1);
    check(0, 1, "R5 restart phase 0");
    goTo(127);
    check(1, 1, "R5 restart phase 1");
  endtask

  // R6: enable low forces low and restarts at phase 0
  task automatic testEnable();
    goTo(edgeCnt + 500);
    enable = 1'b0;
    step(1);
    check(0, 0, "R6 disabled low");
    step(50);
    check(0, 0, "R6 disabled held");
    enable = 1'b1;
    edgeCnt = 0;
    step(2);
    check(0, 1, "R6 restart phase 0");
    goTo(126 + PER * 4);
    check(4, 1, "R6 R3 negative half");
  endtask

  // R1: asynchronous reset mid-run
  task automatic testMidReset();
    #1 rstN = 1'b0;
    #1;
    check(0, 0, "R1 async reset");
    step(2);
    rstN = 1'b1;
    step(1);
    check(0, 0, "R1 after release");
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testFrame();
    testDataChange();
    testPortMode();
    testBackup();
    testEnable();
    testMidReset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule